// File: doc/BRIEF.md
# Quadrature Position Decoder with Index and Home Capture

This block turns the two phase signals of an incremental encoder into a signed position count. Each phase input passes a two-stage synchronizer and then a debounce filter. The filter accepts a new level only after that level has been sampled on `FILT_N` consecutive clocks. The filtered pair is decoded as a Gray sequence. One step in the forward sense (phase A leading phase B) adds one to the count. One step in the other sense subtracts one. A step in which both phases change together cannot be resolved. It leaves the count unchanged and adds one to a saturating error counter.

Two capture registers sample the count on external events. The home capture fires on a falling edge of the active-low home input, with no condition on the phases. The index capture is armed by a falling edge of the active-low index input. It fires only after phase A and phase B have each fallen since arming, at the later of those two falls. Each capture register has a valid flag. Once the flag is set, the stored value is frozen and later triggers are ignored. A one-cycle read strobe clears the flag so that the next trigger can load a new value.

Top module: `qdec_capture`

## Requirements
- R1: During and after reset, `position` is 0, `err_count` is 0, and both valid flags are 0.
- R2: Take the filtered pair {A,B} through the order 00, 10, 11, 01, 00. Each single-phase step forward in that order adds 1 to `position`, and each step backward subtracts 1. Holding the same pair leaves `position` unchanged.
- R3: A change on a phase input that lasts fewer than `FILT_N` clock samples (3 by default) has no effect on `position` or `err_count`.
- R4: When both filtered phases change in the same cycle, `position` is unchanged and `err_count` increases by 1.
- R5: `position` is a `POS_W`-bit two's-complement count that wraps. One backward step from 0 gives all ones.
- R6: After a falling edge of `index_n`, the index capture loads the count as it stands after the later of the next falling edge of A and the next falling edge of B, and sets `idx_valid`.
- R7: Falling edges of A and B with no preceding falling edge of `index_n` do not set `idx_valid`.
- R8: A falling edge of `home_n` loads the current count into `home_cap` and sets `home_valid`, whatever the levels of A and B.
- R9: While a valid flag is set and its read strobe is low, the flag stays set and its capture register keeps its value, even when new triggers arrive.
- R10: A one-cycle read strobe clears its valid flag on the next clock. A later trigger then loads a new value.
- R11: `err_count` never decreases and saturates at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| index_n | input | 1 | Encoder index, active low, asynchronous |
| home_n | input | 1 | Home switch, active low, asynchronous |
| idx_read | input | 1 | Read strobe that clears `idx_valid` |
| home_read | input | 1 | Read strobe that clears `home_valid` |
| position | output | POS_W | Signed position count |
| idx_cap | output | POS_W | Count captured on an index event |
| idx_valid | output | 1 | Index capture holds an unread value |
| home_cap | output | POS_W | Count captured on a home event |
| home_valid | output | 1 | Home capture holds an unread value |
| err_count | output | ERR_W | Saturating count of illegal double-phase steps |

## Verification
The step-size property assumes that the filtered phases change at most once per clock. This is true because each phase must be sampled the same way several times before it is accepted. The hold and clear properties assume that a read strobe is one cycle wide. The stimulus holds every encoder state for eight clocks, well beyond the synchronizer and filter delay. It pulses each read strobe for exactly one clock and keeps index and home pulses longer than the synchronizer.

// File: rtl/qdec_capture.sv
module qdec_capture #(
  parameter int POS_W  = 32,
  parameter int FILT_N = 3,
  parameter int ERR_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             index_n,
  input  logic             home_n,
  input  logic             idx_read,
  input  logic             home_read,
  output logic [POS_W-1:0] position,
  output logic [POS_W-1:0] idx_cap,
  output logic             idx_valid,
  output logic [POS_W-1:0] home_cap,
  output logic             home_valid,
  output logic [ERR_W-1:0] err_count
);
  localparam int CNT_W = (FILT_N < 2) ? 1 : $clog2(FILT_N);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_N - 1);
  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

  // bit 1 = phase A, bit 0 = phase B
  logic [1:0] ab_m, ab_s, filt, filt_nxt, take;
  logic [CNT_W-1:0] fcnt [2];
  // bit 1 = home, bit 0 = index
  logic [1:0] hx_m, hx_s, hx_d;
  logic [1:0] warm;
  logic warm_done, moved, illegal, step_up;
  logic a_fall, b_fall, idx_fall, home_fall;
  logic armed, seen_a, seen_b, idx_hit;
  logic [POS_W-1:0] pos_nxt;

  assign warm_done = (warm == 2'd3);

  always_comb begin
    for (int ch = 0; ch < 2; ch++) begin
      take[ch]     = warm_done && (ab_s[ch] != filt[ch]) && (fcnt[ch] == CNT_LAST);
      filt_nxt[ch] = take[ch] ? ab_s[ch] : filt[ch];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_m    <= 2'b00;
      ab_s    <= 2'b00;
      hx_m    <= 2'b11;
      hx_s    <= 2'b11;
      hx_d    <= 2'b11;
      warm    <= 2'd0;
      filt    <= 2'b00;
      fcnt[0] <= '0;
      fcnt[1] <= '0;
    end else begin
      ab_m <= {enc_a, enc_b};
      ab_s <= ab_m;
      hx_m <= {home_n, index_n};
      hx_s <= hx_m;
      hx_d <= hx_s;
      if (!warm_done) warm <= warm + 2'd1;
      for (int ch = 0; ch < 2; ch++) begin
        if (!warm_done) begin
          filt[ch] <= ab_s[ch];
          fcnt[ch] <= '0;
        end else if (ab_s[ch] == filt[ch] || take[ch]) begin
          filt[ch] <= filt_nxt[ch];
          fcnt[ch] <= '0;
        end else begin
          fcnt[ch] <= fcnt[ch] + CNT_W'(1);
        end
      end
    end
  end

  assign moved   = warm_done && (filt_nxt != filt);
  assign illegal = warm_done && (&(filt_nxt ^ filt));
  assign step_up = filt_nxt[1] ^ filt[0];
  assign pos_nxt = (moved && !illegal) ? (step_up ? position + POS_W'(1) : position - POS_W'(1))
                                       : position;

  assign a_fall    = warm_done & filt[1] & ~filt_nxt[1];
  assign b_fall    = warm_done & filt[0] & ~filt_nxt[0];
  assign idx_fall  = hx_d[0] & ~hx_s[0];
  assign home_fall = hx_d[1] & ~hx_s[1];
  assign idx_hit   = armed & (seen_a | a_fall) & (seen_b | b_fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      position  <= '0;
      err_count <= '0;
      armed     <= 1'b0;
      seen_a    <= 1'b0;
      seen_b    <= 1'b0;
    end else begin
      position <= pos_nxt;
      if (illegal && err_count != ERR_MAX) err_count <= err_count + ERR_W'(1);
      if (idx_fall) begin
        armed  <= 1'b1;
        seen_a <= 1'b0;
        seen_b <= 1'b0;
      end else if (idx_hit) begin
        armed  <= 1'b0;
        seen_a <= 1'b0;
        seen_b <= 1'b0;
      end else if (armed) begin
        seen_a <= seen_a | a_fall;
        seen_b <= seen_b | b_fall;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_valid  <= 1'b0;
      idx_cap    <= '0;
      home_valid <= 1'b0;
      home_cap   <= '0;
    end else begin
      idx_valid  <= (idx_valid & ~idx_read) | (idx_hit & ~idx_valid);
      home_valid <= (home_valid & ~home_read) | (home_fall & ~home_valid);
      if (idx_hit && !idx_valid) idx_cap <= pos_nxt;
      if (home_fall && !home_valid) home_cap <= pos_nxt;
    end
  end
endmodule

module qdec_capture_chk #(
  parameter int POS_W = 32,
  parameter int ERR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [POS_W-1:0] position,
  input logic [ERR_W-1:0] err_count,
  input logic [POS_W-1:0] idx_cap,
  input logic             idx_valid,
  input logic             idx_read,
  input logic [POS_W-1:0] home_cap,
  input logic             home_valid,
  input logic             home_read
);
  localparam logic [POS_W-1:0] ONE = POS_W'(1);

  p_unit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (position == $past(position)) || (position == $past(position) + ONE) ||
    (position == $past(position) - ONE));

  p_err_freezes_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count != $past(err_count)) |-> (position == $past(position)));

  p_err_monotonic_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_count >= $past(err_count));

  p_idx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_valid && !idx_read) |=> (idx_valid && $stable(idx_cap)));

  p_home_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (home_valid && !home_read) |=> (home_valid && $stable(home_cap)));

  p_idx_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_valid && idx_read) |=> !idx_valid);

  p_home_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (home_valid && home_read) |=> !home_valid);
endmodule

bind qdec_capture qdec_capture_chk #(.POS_W(POS_W), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .position(position), .err_count(err_count),
  .idx_cap(idx_cap), .idx_valid(idx_valid), .idx_read(idx_read),
  .home_cap(home_cap), .home_valid(home_valid), .home_read(home_read)
);

// File: tb/test_qdec_capture.sv
`timescale 1ns/1ps
module test_qdec_capture;
  localparam int POS_W = 32;
  localparam int ERR_W = 4;
  localparam int ERR_SAT = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_a = 1'b0, enc_b = 1'b0, index_n = 1'b1, home_n = 1'b1;
  logic idx_read = 1'b0, home_read = 1'b0;
  logic [POS_W-1:0] position, idx_cap, home_cap;
  logic idx_valid, home_valid;
  logic [ERR_W-1:0] err_count;

  int checks = 0, errors = 0;
  logic [1:0] cur = 2'b00;
  logic [POS_W-1:0] exp_pos = '0;
  int exp_err = 0;
  logic [POS_W-1:0] held;

  always #4 clk = ~clk;

  qdec_capture #(.POS_W(POS_W), .FILT_N(3), .ERR_W(ERR_W)) i_qdec_capture (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .index_n(index_n),
    .home_n(home_n), .idx_read(idx_read), .home_read(home_read),
    .position(position), .idx_cap(idx_cap), .idx_valid(idx_valid),
    .home_cap(home_cap), .home_valid(home_valid), .err_count(err_count));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int gray_pos(input logic [1:0] ab);
    case (ab)
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic go(input logic [1:0] nxt);
    int d;
    d = (gray_pos(nxt) - gray_pos(cur) + 4) % 4;
    if (d == 1) exp_pos = exp_pos + 1;
    else if (d == 3) exp_pos = exp_pos - 1;
    else if (d == 2 && exp_err < ERR_SAT) exp_err++;
    cur = nxt;
    @(negedge clk);
    {enc_a, enc_b} = nxt;
    repeat (8) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic goto11();
    while (cur != 2'b11) begin
      case (cur)
        2'b00: go(2'b10);
        2'b10: go(2'b11);
        default: go(2'b00);
      endcase
    end
  endtask

  task automatic index_seq();
    goto11();
    index_n = 1'b0;
    repeat (6) @(negedge clk);
    go(2'b01);
    go(2'b00);
    index_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic home_pulse();
    @(negedge clk);
    home_n = 1'b0;
    repeat (6) @(negedge clk);
    home_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic strobe_idx();
    @(negedge clk); idx_read = 1'b1;
    @(negedge clk); idx_read = 1'b0;
  endtask

  task automatic strobe_home();
    @(negedge clk); home_read = 1'b1;
    @(negedge clk); home_read = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 position in reset", position, 0);
    check("R1 idx_valid in reset", idx_valid, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 position after reset", position, 0);
    check("R1 err_count after reset", err_count, 0);
    check("R1 home_valid after reset", home_valid, 0);

    go(2'b01);
    check("R5 wrap below zero", position, {POS_W{1'b1}});
    go(2'b00);
    check("R5 wrap back to zero", position, 0);

    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        go(2'(f));
        go(2'(t));
        check("R2 sweep position", position, exp_pos);
        check("R4 sweep err_count", err_count, exp_err);
      end
    end
    for (int k = 0; k < 8; k++) go(k[0] ? 2'b00 : 2'b10);
    check("R2 back-and-forth position", position, exp_pos);

    held = position;
    @(negedge clk); enc_a = ~enc_a;
    repeat (2) @(negedge clk); enc_a = ~enc_a;
    repeat (10) @(negedge clk);
    check("R3 short glitch on A ignored", position, held);
    check("R3 short glitch err unchanged", err_count, exp_err);
    @(negedge clk); enc_b = ~enc_b;
    @(negedge clk); enc_b = ~enc_b;
    repeat (10) @(negedge clk);
    check("R3 one-clock glitch on B ignored", position, held);

    goto11();
    go(2'b01);
    go(2'b00);
    check("R7 falls without index", idx_valid, 0);

    index_seq();
    check("R6 index valid", idx_valid, 1);
    check("R6 index capture at later fall", idx_cap, exp_pos);
    held = exp_pos;
    index_seq();
    check("R9 index second trigger ignored", idx_cap, held);
    check("R9 index valid still set", idx_valid, 1);
    strobe_idx();
    check("R10 index cleared by read", idx_valid, 0);
    index_seq();
    check("R10 index recapture", idx_cap, exp_pos);
    check("R10 index valid again", idx_valid, 1);

    go(2'b10);
    home_pulse();
    check("R8 home valid", home_valid, 1);
    check("R8 home capture", home_cap, exp_pos);
    held = exp_pos;
    go(2'b11);
    home_pulse();
    check("R9 home second trigger ignored", home_cap, held);
    strobe_home();
    check("R10 home cleared by read", home_valid, 0);
    go(2'b01);
    home_pulse();
    check("R10 home recapture", home_cap, exp_pos);

    held = exp_pos;
    for (int k = 0; k < 20; k++) go(cur ^ 2'b11);
    check("R11 err_count saturates", err_count, ERR_SAT);
    check("R4 position frozen by illegal steps", position, held);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule